// File: doc/BRIEF.md
# Command/Indicate Channel Transmit Controller

This block places a short command/indicate code into a fixed slot of each serial frame and gives the processor a handshake for it. The processor writes one 8-bit control register. The low four bits hold the code and the next bit is a ready flag. Writing the flag as one starts a transfer: the code goes onto the line, most significant bit first, in the slot that the frame timing logic marks with a slot strobe.

A transfer finishes only after the slot has carried the code in two frames that follow each other. The frame-sync pulse closes each frame. When the transfer finishes, the block clears the ready flag, raises an acknowledge status bit and sets an interrupt flag. The interrupt output is masked by an enable input, and a read of the control register clears the flag. When no transfer is running, the slot keeps carrying the last code sent.

Top module: `ci_tx_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the acknowledge and interrupt are low, and the serial line is high.
- R2: In the control register, bits 3..0 are the code and bit 4 is the ready flag. Bits 7..5 always read zero. A write with bit 4 set, made while ready is clear, starts a transfer and loads the code.
- R3: While the slot strobe is high, the line carries the code one bit per cycle, bit 3 first. While the strobe is low, the line is high.
- R4: When no transfer is running, each slot repeats the last code that was started.
- R5: The acknowledge is raised at the frame-sync pulse that closes the second of two back-to-back frames in which the complete slot went out after the start. A frame-sync pulse that closes a frame with no slot resets the count.
- R6: When the acknowledge is raised, the ready flag clears by itself in the same cycle.
- R7: While ready is set, register writes have no effect: the code and the ready flag are unchanged.
- R8: When a transfer completes, a pending interrupt flag is set and a read of the control register clears it. The interrupt output is the flag ANDed with the enable input.
- R9: The acknowledge stays high until the next write that starts a transfer, and that write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wdata | input | 8 | Control register write data |
| rd_en | input | 1 | Control register read strobe (clears the pending interrupt) |
| rdata | output | 8 | Control register read value |
| ack | output | 1 | Acknowledge status bit |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Maskable completion interrupt |
| fsync | input | 1 | Frame-sync pulse, one cycle per frame |
| slot_en | input | 1 | Slot strobe, high for four cycles per frame |
| ci_out | output | 1 | Serial line output |

## Verification
The transfer is run with an unbroken sequence of frames that each carry the slot. This shows that the acknowledge needs exactly two counted frames and does not come one frame early. Another run leaves the slot out of one frame in the middle. This tells a count that restarts apart from one that only pauses, because the two complete at different frame-sync pulses. Codes with mixed bit patterns (1010, 0101, 1100) are sent, which exposes a reversed bit order or a misplaced bit. Writes made during a transfer, and a write with the reserved bits set, check the register guarding and the readback layout. Completion is tried once with the interrupt enable low and once with it high, which separates the pending flag from the masked output.

// File: rtl/ci_tx_ctrl.sv
module ci_tx_ctrl #(
  parameter int CODE_W  = 4,
  parameter int REPEATS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       rd_en,
  output logic [7:0] rdata,
  output logic       ack,
  input  logic       irq_en,
  output logic       irq,
  input  logic       fsync,
  input  logic       slot_en,
  output logic       ci_out
);
  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam int CNT_W = $clog2(REPEATS + 1);

  logic [CODE_W-1:0] code, line_code;
  logic [IDX_W-1:0]  idx;
  logic [CNT_W-1:0]  cnt;
  logic              ready, pend, armed, driven;

  wire start     = wr_en && !ready && wdata[CODE_W];
  wire slot_last = slot_en && (idx == IDX_W'(CODE_W - 1));
  wire done      = fsync && ready && driven && (cnt == CNT_W'(REPEATS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code <= '0; line_code <= '0; ready <= 1'b0; ack <= 1'b0;
      pend <= 1'b0; armed <= 1'b0; driven <= 1'b0; cnt <= '0; idx <= '0;
    end else begin
      if (fsync) idx <= '0;
      else if (slot_en) idx <= slot_last ? '0 : idx + 1'b1;

      if (start) begin
        code      <= wdata[CODE_W-1:0];
        line_code <= wdata[CODE_W-1:0];
        ready     <= 1'b1;
        ack       <= 1'b0;
        cnt       <= '0;
        driven    <= 1'b0;
        armed     <= 1'b0;
      end else begin
        if (wr_en && !ready) code <= wdata[CODE_W-1:0];
        if (slot_en && idx == '0) armed <= ready;
        if (fsync) driven <= 1'b0;
        else if (slot_last && armed && ready) driven <= 1'b1;
        if (fsync && ready) cnt <= done ? '0 : (driven ? cnt + 1'b1 : '0);
        if (done) begin
          ready <= 1'b0;
          ack   <= 1'b1;
        end
      end

      if (done) pend <= 1'b1;
      else if (rd_en) pend <= 1'b0;
    end
  end

  assign rdata  = {{(7 - CODE_W){1'b0}}, ready, code};
  assign irq    = pend & irq_en;
  assign ci_out = slot_en ? line_code[IDX_W'(CODE_W - 1) - idx] : 1'b1;

  // R6
  ready_fall_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> ack);
  // R9
  ack_ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> !ready);
  // R7
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> (code == $past(code)));
  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
  // R8
  pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $rose(ack));
endmodule

// File: tb/sim_ci_tx_ctrl.sv
module sim_ci_tx_ctrl;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, irq_en = 0, fsync = 0, slot_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic ack, irq, ci_out;
  int vectors = 0, miscompares = 0;
  logic [3:0] expq[$];
  logic [3:0] exp_line = 4'h0;
  logic [3:0] got = 0;
  int nb = 0;

  always #5 clk = ~clk;

  ci_tx_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rd_en(rd_en),
    .rdata(rdata), .ack(ack), .irq_en(irq_en), .irq(irq), .fsync(fsync),
    .slot_en(slot_en), .ci_out(ci_out));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1; wdata = d; tick(1); wr_en = 0;
  endtask

  task automatic rd();
    rd_en = 1; tick(1); rd_en = 0;
  endtask

  task automatic frame(input bit with_slot);
    fsync = 1; tick(1); fsync = 0; tick(2);
    if (with_slot) begin
      expq.push_back(exp_line);
      slot_en = 1; tick(4); slot_en = 0;
    end
    tick(2);
  endtask

  // R3 R4 monitor: compares each slot against the scoreboard queue
  always @(negedge clk) begin
    if (slot_en) begin
      got = {got[2:0], ci_out};
      nb++;
      if (nb == 4) begin
        nb = 0;
        if (expq.size() == 0) chk("R3 unexpected slot", {4'h0, got}, 8'hxx);
        else chk("R3/R4 slot code", {4'h0, got}, {4'h0, expq.pop_front()});
      end
    end else if (rst_n) begin
      if (ci_out !== 1'b1) chk("R3 idle line", {7'h0, ci_out}, 8'h01);
    end
  end

  initial begin
    #1_000_000;
    miscompares++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick(1);
    // R1
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 ack", {7'h0, ack}, 8'h00);
    chk("R1 irq", {7'h0, irq}, 8'h00);
    chk("R1 line", {7'h0, ci_out}, 8'h01);

    irq_en = 1;
    // R2: reserved bits set in write, read back zero
    wr(8'hFA); exp_line = 4'hA;
    chk("R2 readback", rdata, 8'h1A);
    frame(1); frame(1);
    // R5: not yet after one counted frame
    chk("R5 early ack", {7'h0, ack}, 8'h00);
    chk("R6 ready held", rdata, 8'h1A);
    frame(1);
    chk("R5 ack", {7'h0, ack}, 8'h01);
    chk("R6 ready cleared", rdata, 8'h0A);
    chk("R8 irq set", {7'h0, irq}, 8'h01);
    frame(1); // R4: idle slot keeps code A
    rd(); tick(1);
    chk("R8 irq cleared by read", {7'h0, irq}, 8'h00);
    chk("R9 ack held after read", {7'h0, ack}, 8'h01);

    // second transfer, interrupt masked
    irq_en = 0;
    wr(8'h15); exp_line = 4'h5;
    chk("R9 ack cleared by start", {7'h0, ack}, 8'h00);
    wr(8'h13);
    chk("R7 write ignored", rdata, 8'h15);
    wr(8'h02);
    chk("R7 clear-ready write ignored", rdata, 8'h15);
    frame(1); frame(1); frame(1);
    chk("R5 ack second", {7'h0, ack}, 8'h01);
    chk("R8 masked irq", {7'h0, irq}, 8'h00);
    irq_en = 1; tick(1);
    chk("R8 enable exposes pending", {7'h0, irq}, 8'h01);
    rd(); tick(1);
    chk("R8 cleared", {7'h0, irq}, 8'h00);

    // gap test: a frame without the slot restarts the count
    wr(8'h1C); exp_line = 4'hC;
    frame(1); frame(0); frame(1); frame(1);
    chk("R5 gap restarts count", {7'h0, ack}, 8'h00);
    frame(1);
    chk("R5 ack after gap", {7'h0, ack}, 8'h01);
    chk("R6 ready cleared after gap", rdata, 8'h0C);
    frame(1);
    tick(2);
    chk("R3 queue drained", {7'h0, expq.size() == 0}, 8'h01);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule